// File: doc/BRIEF.md
# Hardware Semaphore Bank

This block holds a bank of hardware semaphores that several processors on one chip share through simple register ports. Each processor has its own port with 32-bit reads and writes. A port also carries a master-ID sideband. Every semaphore is one word-aligned register. To take a semaphore, a master writes its 4-bit identifier into the register, then reads the register back. It holds the lock only if the returned owner nibble equals its own identifier. The holder frees the semaphore by writing zero.

Claims never need an atomic read-modify-write. Contention is settled inside the bank, on the write itself. A claim to a held semaphore is dropped. A release counts only when the sideband ID matches the stored owner. When several ports claim the same free semaphore in one cycle, the lowest port index wins.

A control word selects the protocol. In the polled protocol no event flags are raised. In the other protocol, every release raises a per-semaphore pending flag. A clear-all register reads back these flags and wipes them when written with a fixed key. The software-facing behaviour of the polled protocol is unchanged.

Top module: `hsem_bank`

## Requirements
- R1: Semaphore s (0 to NUM_SEMS-1) sits at byte address 0x08 + 4*s. A read returns the owner ID in bits [3:0] with bits [31:4] zero. bus_rvalid and bus_rdata appear on the clock edge that follows the read request, and reflect state before any write in the request cycle.
- R2: A write whose bits [3:0] are nonzero to a free semaphore makes that nibble the owner. A read in the next cycle returns it. Only bits [3:0] of a semaphore write are significant.
- R3: A write with nonzero bits [3:0] to a held semaphore is ignored, even from its owner, and the stored owner stays unchanged.
- R4: A write with bits [3:0] equal to zero frees a held semaphore only if that port's bus_mid equals the stored owner. Otherwise it is ignored.
- R5: If several ports claim one free semaphore in the same cycle, the lowest port index wins. If, in one cycle, the owner releases a held semaphore while another port claims it, the semaphore ends free.
- R6: The control word at 0x00 stores bit 0 as the protocol select, where 0 means polled. Its other bits read zero. If several ports write it in one cycle, the lowest port index wins.
- R7: In a cycle where control bit 0 is 1, releasing semaphore s sets bit s of the pending-flag word. Reads at 0x90 return that word. While bit 0 is 0, releases set no flag.
- R8: A write of exactly 0x0000FFFF to 0x90 clears all pending flags. Any other value written there has no effect.
- R9: Writes to any other address, including misaligned ones, change nothing. Reads of such addresses return zero.
- R10: After a synchronous active-low reset, every semaphore is free, every pending flag is clear and control bit 0 is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_req | input | NUM_PORTS | Per-port access request |
| bus_we | input | NUM_PORTS | Per-port write enable (0 = read) |
| bus_addr | input | NUM_PORTS x ADDR_W | Per-port byte address |
| bus_wdata | input | NUM_PORTS x DATA_W | Per-port write data |
| bus_mid | input | NUM_PORTS x ID_W | Per-port master-ID sideband |
| bus_rvalid | output | NUM_PORTS | Read data valid, one cycle after a read request |
| bus_rdata | output | NUM_PORTS x DATA_W | Registered read data |

## Verification
The bench builds the bank with three ports and the default 32 semaphores. With a third port, ports 1 and 2 can contend without port 0, so the lowest-index rule is exercised on more than one pair. With 32 semaphores the last register, at 0x84, and pending-flag bit 31 are both reachable. The first address past the bank, 0x88, is also reachable as an unmapped address.

// File: rtl/hsem_pkg.sv
// Shared constants and types for the hardware semaphore bank.
// Assumes byte addressing with word-aligned registers.
package hsem_pkg;
    localparam int CTRL_OFS = 'h00;
    localparam int SEM_BASE = 'h08;
    localparam int CLR_OFS  = 'h90;
    localparam logic [31:0] CLR_KEY = 32'h0000_FFFF;

    typedef enum logic [1:0] {
        TGT_NONE = 2'd0,
        TGT_CTRL = 2'd1,
        TGT_SEM  = 2'd2,
        TGT_CLR  = 2'd3
    } hsem_tgt_e;
endpackage

// File: rtl/hsem_decode.sv
// Address decoder for one port: maps a byte address to a register target
// and a semaphore index. Assumes the semaphore window ends below CLR_OFS.
module hsem_decode #(
    parameter int ADDR_W   = 8,
    parameter int NUM_SEMS = 32,
    localparam int IDX_W   = $clog2(NUM_SEMS)
) (
    input  logic [ADDR_W-1:0]  addr,
    output hsem_pkg::hsem_tgt_e tgt,
    output logic [IDX_W-1:0]   sem_idx
);
    import hsem_pkg::*;

    // Compare against every register address; misaligned addresses match none.
    always_comb begin
        tgt     = TGT_NONE;
        sem_idx = '0;
        if (addr == ADDR_W'(CTRL_OFS)) begin
            tgt = TGT_CTRL;
        end else if (addr == ADDR_W'(CLR_OFS)) begin
            tgt = TGT_CLR;
        end else begin
            for (int s = 0; s < NUM_SEMS; s++) begin
                if (addr == ADDR_W'(SEM_BASE + 4 * s)) begin
                    tgt     = TGT_SEM;
                    sem_idx = IDX_W'(s);
                end
            end
        end
    end
endmodule

// File: rtl/hsem_slot.sv
// One semaphore: stores the owner ID and arbitrates same-cycle writes.
// Assumes owner ID zero means free. Claims are only seen while free;
// releases are only seen while held.
module hsem_slot #(
    parameter int NUM_PORTS = 2,
    parameter int ID_W      = 4
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [NUM_PORTS-1:0]           wr_en,
    input  logic [NUM_PORTS-1:0][ID_W-1:0] wnib,
    input  logic [NUM_PORTS-1:0][ID_W-1:0] mid,
    output logic [ID_W-1:0]                owner,
    output logic                           rel_pulse
);
    logic [ID_W-1:0] owner_nxt;
    logic            claimed;

    // Pick the lowest-index claimer when free, or detect an owner release when held.
    always_comb begin
        owner_nxt = owner;
        rel_pulse = 1'b0;
        claimed   = 1'b0;
        if (owner == '0) begin
            for (int p = 0; p < NUM_PORTS; p++) begin
                if (!claimed && wr_en[p] && wnib[p] != '0) begin
                    owner_nxt = wnib[p];
                    claimed   = 1'b1;
                end
            end
        end else begin
            for (int p = 0; p < NUM_PORTS; p++) begin
                if (wr_en[p] && wnib[p] == '0 && mid[p] == owner) begin
                    rel_pulse = 1'b1;
                end
            end
            if (rel_pulse) begin
                owner_nxt = '0;
            end
        end
    end

    // Owner register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            owner <= '0;
        end else begin
            owner <= owner_nxt;
        end
    end
endmodule

// File: rtl/hsem_ctrl.sv
// Protocol-select bit and pending release flags with a keyed clear-all.
// Assumes NUM_SEMS is at most DATA_W. A flag set in the same cycle as a
// clear survives the clear.
module hsem_ctrl #(
    parameter int NUM_PORTS = 2,
    parameter int NUM_SEMS  = 32,
    parameter int DATA_W    = 32
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [NUM_PORTS-1:0]             ctrl_wr,
    input  logic [NUM_PORTS-1:0]             clr_wr,
    input  logic [NUM_PORTS-1:0][DATA_W-1:0] wdata,
    input  logic [NUM_SEMS-1:0]              rel,
    output logic                             proto,
    output logic [NUM_SEMS-1:0]              flags
);
    logic                proto_nxt;
    logic                clr_hit;
    logic [NUM_SEMS-1:0] flags_nxt;

    // Lowest port wins a control write: it is applied last.
    always_comb begin
        proto_nxt = proto;
        for (int p = NUM_PORTS - 1; p >= 0; p--) begin
            if (ctrl_wr[p]) begin
                proto_nxt = wdata[p][0];
            end
        end
    end

    // Any port writing the exact key clears all flags.
    always_comb begin
        clr_hit = 1'b0;
        for (int p = 0; p < NUM_PORTS; p++) begin
            if (clr_wr[p] && wdata[p] == DATA_W'(hsem_pkg::CLR_KEY)) begin
                clr_hit = 1'b1;
            end
        end
        flags_nxt = clr_hit ? '0 : flags;
        if (proto) begin
            flags_nxt = flags_nxt | rel;
        end
    end

    // Control and flag registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            proto <= 1'b0;
            flags <= '0;
        end else begin
            proto <= proto_nxt;
            flags <= flags_nxt;
        end
    end
endmodule

// File: rtl/hsem_bank.sv
// Top of the semaphore bank: per-port decode, one slot per semaphore,
// control/flag block and a registered read path per port.
// Assumes a read sees state from before any write in the same cycle.
module hsem_bank #(
    parameter int NUM_PORTS = 2,
    parameter int NUM_SEMS  = 32,
    parameter int ID_W      = 4,
    parameter int ADDR_W    = 8,
    parameter int DATA_W    = 32
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [NUM_PORTS-1:0]             bus_req,
    input  logic [NUM_PORTS-1:0]             bus_we,
    input  logic [NUM_PORTS-1:0][ADDR_W-1:0] bus_addr,
    input  logic [NUM_PORTS-1:0][DATA_W-1:0] bus_wdata,
    input  logic [NUM_PORTS-1:0][ID_W-1:0]   bus_mid,
    output logic [NUM_PORTS-1:0]             bus_rvalid,
    output logic [NUM_PORTS-1:0][DATA_W-1:0] bus_rdata
);
    import hsem_pkg::*;

    localparam int IDX_W = $clog2(NUM_SEMS);

    hsem_tgt_e                            port_tgt [NUM_PORTS];
    logic [NUM_PORTS-1:0][IDX_W-1:0]      port_idx;
    logic [NUM_PORTS-1:0][ID_W-1:0]       port_nib;
    logic [NUM_PORTS-1:0]                 ctrl_wr;
    logic [NUM_PORTS-1:0]                 clr_wr;
    logic [NUM_SEMS-1:0][NUM_PORTS-1:0]   sem_wr;
    logic [NUM_SEMS-1:0][ID_W-1:0]        sem_owner;
    logic [NUM_SEMS-1:0]                  sem_rel;
    logic                                 ctrl_proto;
    logic [NUM_SEMS-1:0]                  irq_flags;

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        hsem_decode #(
            .ADDR_W   (ADDR_W),
            .NUM_SEMS (NUM_SEMS)
        ) u_dec (
            .addr    (bus_addr[p]),
            .tgt     (port_tgt[p]),
            .sem_idx (port_idx[p])
        );

        // Per-port write strobes towards control and clear registers.
        always_comb begin
            port_nib[p] = bus_wdata[p][ID_W-1:0];
            ctrl_wr[p]  = bus_req[p] && bus_we[p] && port_tgt[p] == TGT_CTRL;
            clr_wr[p]   = bus_req[p] && bus_we[p] && port_tgt[p] == TGT_CLR;
        end

        // Registered read data for this port.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                bus_rvalid[p] <= 1'b0;
                bus_rdata[p]  <= '0;
            end else begin
                bus_rvalid[p] <= bus_req[p] && !bus_we[p];
                bus_rdata[p]  <= '0;
                if (bus_req[p] && !bus_we[p]) begin
                    case (port_tgt[p])
                        TGT_CTRL: bus_rdata[p] <= DATA_W'(ctrl_proto);
                        TGT_SEM:  bus_rdata[p] <= DATA_W'(sem_owner[port_idx[p]]);
                        TGT_CLR:  bus_rdata[p] <= DATA_W'(irq_flags);
                        default:  bus_rdata[p] <= '0;
                    endcase
                end
            end
        end
    end

    for (genvar s = 0; s < NUM_SEMS; s++) begin : g_sem
        // Route each port's semaphore write to this slot.
        always_comb begin
            for (int p = 0; p < NUM_PORTS; p++) begin
                sem_wr[s][p] = bus_req[p] && bus_we[p] && port_tgt[p] == TGT_SEM
                               && port_idx[p] == IDX_W'(s);
            end
        end

        hsem_slot #(
            .NUM_PORTS (NUM_PORTS),
            .ID_W      (ID_W)
        ) u_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_en     (sem_wr[s]),
            .wnib      (port_nib),
            .mid       (bus_mid),
            .owner     (sem_owner[s]),
            .rel_pulse (sem_rel[s])
        );
    end

    hsem_ctrl #(
        .NUM_PORTS (NUM_PORTS),
        .NUM_SEMS  (NUM_SEMS),
        .DATA_W    (DATA_W)
    ) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .ctrl_wr (ctrl_wr),
        .clr_wr  (clr_wr),
        .wdata   (bus_wdata),
        .rel     (sem_rel),
        .proto   (ctrl_proto),
        .flags   (irq_flags)
    );
endmodule

// File: rtl/hsem_bank_chk.sv
// Property checker for hsem_bank. It recomputes from the bus which
// semaphore writes may legally claim or release, and watches the stored
// state for changes that break those rules.
module hsem_bank_chk #(
    parameter int NUM_PORTS = 2,
    parameter int NUM_SEMS  = 32,
    parameter int ID_W      = 4,
    parameter int ADDR_W    = 8
) (
    input logic                             clk,
    input logic                             rst_n,
    input logic [NUM_PORTS-1:0]             bus_req,
    input logic [NUM_PORTS-1:0]             bus_we,
    input logic [NUM_PORTS-1:0][ADDR_W-1:0] bus_addr,
    input logic [NUM_PORTS-1:0][ID_W-1:0]   wnib,
    input logic [NUM_PORTS-1:0][ID_W-1:0]   bus_mid,
    input logic [NUM_PORTS-1:0]             bus_rvalid,
    input logic [NUM_SEMS-1:0][ID_W-1:0]    owners,
    input logic [NUM_SEMS-1:0]              flags,
    input logic                             proto
);
    logic [NUM_SEMS-1:0] may_claim;
    logic [NUM_SEMS-1:0] may_release;

    // Which semaphores saw a nonzero write, or a zero write from their owner.
    always_comb begin
        may_claim   = '0;
        may_release = '0;
        for (int s = 0; s < NUM_SEMS; s++) begin
            for (int p = 0; p < NUM_PORTS; p++) begin
                if (bus_req[p] && bus_we[p] && bus_addr[p] == ADDR_W'(hsem_pkg::SEM_BASE + 4 * s)) begin
                    if (wnib[p] != '0) may_claim[s] = 1'b1;
                    if (wnib[p] == '0 && bus_mid[p] == owners[s]) may_release[s] = 1'b1;
                end
            end
        end
    end

    for (genvar s = 0; s < NUM_SEMS; s++) begin : g_chk
        AST_CLAIM_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(owners[s]) == '0 && owners[s] != '0) |-> $past(may_claim[s])); // R2
        AST_HELD_NOT_STOLEN: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(owners[s]) != '0) |-> (owners[s] == $past(owners[s]) || owners[s] == '0)); // R3
        AST_RELEASE_BY_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(owners[s]) != '0 && owners[s] == '0) |-> $past(may_release[s])); // R4
    end

    AST_READ_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (bus_rvalid == $past(bus_req & ~bus_we))); // R1
    AST_FLAG_NEEDS_PROTO: assert property (@(posedge clk) disable iff (!rst_n)
        ((flags & ~$past(flags)) != '0) |-> $past(proto)); // R7
    AST_RESET_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (owners == '0 && flags == '0 && !proto)); // R10
endmodule

bind hsem_bank hsem_bank_chk #(
    .NUM_PORTS (NUM_PORTS),
    .NUM_SEMS  (NUM_SEMS),
    .ID_W      (ID_W),
    .ADDR_W    (ADDR_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_req    (bus_req),
    .bus_we     (bus_we),
    .bus_addr   (bus_addr),
    .wnib       (port_nib),
    .bus_mid    (bus_mid),
    .bus_rvalid (bus_rvalid),
    .owners     (sem_owner),
    .flags      (irq_flags),
    .proto      (ctrl_proto)
);

// File: tb/hsem_bank_tb.sv
`timescale 1ns/1ps
module hsem_bank_tb;
    localparam int NP = 3;
    localparam int NS = 32;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic [NP-1:0]        req = '0;
    logic [NP-1:0]        we = '0;
    logic [NP-1:0][7:0]   addr = '0;
    logic [NP-1:0][31:0]  wdata = '0;
    logic [NP-1:0][3:0]   mid = '0;
    logic [NP-1:0]        rvalid;
    logic [NP-1:0][31:0]  rdata;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    hsem_bank #(.NUM_PORTS(NP), .NUM_SEMS(NS)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_req(req), .bus_we(we), .bus_addr(addr),
        .bus_wdata(wdata), .bus_mid(mid), .bus_rvalid(rvalid), .bus_rdata(rdata)
    );

    function automatic logic [7:0] sem_a(int s);
        return 8'(8'h08 + 4 * s);
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic set_wr(int p, logic [7:0] a, logic [31:0] d, logic [3:0] m);
        req[p] = 1'b1; we[p] = 1'b1; addr[p] = a; wdata[p] = d; mid[p] = m;
    endtask

    task automatic tick();
        @(posedge clk); #1;
        req = '0; we = '0; addr = '0; wdata = '0; mid = '0;
    endtask

    task automatic wr(int p, logic [7:0] a, logic [31:0] d, logic [3:0] m);
        @(negedge clk); set_wr(p, a, d, m); tick();
    endtask

    task automatic rd_chk(string tag, int p, logic [7:0] a, logic [31:0] exp);
        @(negedge clk);
        req[p] = 1'b1; we[p] = 1'b0; addr[p] = a;
        @(posedge clk); #1;
        chk("R1 rvalid", 32'(rvalid[p]), 32'd1);
        chk(tag, rdata[p], exp);
        req = '0; addr = '0;
    endtask

    task automatic t_reset();
        rd_chk("R10 ctrl", 0, 8'h00, 32'h0);
        rd_chk("R10 flags", 1, 8'h90, 32'h0);
        rd_chk("R10 sem0", 2, sem_a(0), 32'h0);
        rd_chk("R10 sem31", 0, sem_a(31), 32'h0);
    endtask

    task automatic t_claim();
        wr(0, sem_a(3), 32'h1, 4'h1);
        rd_chk("R2 claim", 1, sem_a(3), 32'h1);
        wr(1, sem_a(4), 32'hFFFF_FFF5, 4'h5);
        rd_chk("R1 upper zero", 0, sem_a(4), 32'h5);
        wr(2, sem_a(31), 32'h7, 4'h7);
        rd_chk("R1 last sem", 2, sem_a(31), 32'h7);
    endtask

    task automatic t_held();
        wr(1, sem_a(3), 32'h2, 4'h2);
        rd_chk("R3 foreign claim", 0, sem_a(3), 32'h1);
        wr(0, sem_a(3), 32'h3, 4'h1);
        rd_chk("R3 owner rewrite", 0, sem_a(3), 32'h1);
    endtask

    task automatic t_release();
        wr(1, sem_a(3), 32'h0, 4'h2);
        rd_chk("R4 wrong mid", 1, sem_a(3), 32'h1);
        wr(0, sem_a(3), 32'h0, 4'h1);
        rd_chk("R4 owner release", 1, sem_a(3), 32'h0);
        wr(2, sem_a(4), 32'h0, 4'h5);
        rd_chk("R4 release sem4", 0, sem_a(4), 32'h0);
    endtask

    task automatic t_prio();
        @(negedge clk); set_wr(1, sem_a(7), 32'h6, 4'h6); set_wr(2, sem_a(7), 32'h9, 4'h9); tick();
        rd_chk("R5 ports 1 vs 2", 0, sem_a(7), 32'h6);
        @(negedge clk); set_wr(0, sem_a(8), 32'h3, 4'h3); set_wr(1, sem_a(8), 32'h4, 4'h4);
        set_wr(2, sem_a(8), 32'hA, 4'hA); tick();
        rd_chk("R5 three ports", 2, sem_a(8), 32'h3);
        @(negedge clk); set_wr(0, sem_a(7), 32'h9, 4'h9); set_wr(2, sem_a(7), 32'h0, 4'h6); tick();
        rd_chk("R5 release beats claim", 1, sem_a(7), 32'h0);
    endtask

    task automatic t_ctrl();
        wr(1, 8'h00, 32'hFFFF_FFFF, 4'h1);
        rd_chk("R6 bit0 only", 0, 8'h00, 32'h1);
        @(negedge clk); set_wr(0, 8'h00, 32'h0, 4'h1); set_wr(1, 8'h00, 32'h1, 4'h2); tick();
        rd_chk("R6 lowest port", 2, 8'h00, 32'h0);
    endtask

    task automatic t_flags();
        wr(0, 8'h00, 32'h1, 4'h1);
        wr(0, sem_a(5), 32'hA, 4'hA);
        rd_chk("R7 no flag on claim", 1, 8'h90, 32'h0);
        wr(0, sem_a(5), 32'h0, 4'hA);
        rd_chk("R7 flag bit5", 1, 8'h90, 32'h0000_0020);
        wr(2, sem_a(31), 32'h0, 4'h7);
        rd_chk("R7 flag bit31", 1, 8'h90, 32'h8000_0020);
        wr(1, 8'h90, 32'h0000_00FF, 4'h1);
        rd_chk("R8 wrong key", 0, 8'h90, 32'h8000_0020);
        wr(1, 8'h90, 32'h0000_FFFF, 4'h1);
        rd_chk("R8 key clears", 0, 8'h90, 32'h0);
        wr(0, 8'h00, 32'h0, 4'h1);
        wr(0, sem_a(5), 32'hA, 4'hA);
        wr(0, sem_a(5), 32'h0, 4'hA);
        rd_chk("R7 polled no flag", 2, 8'h90, 32'h0);
    endtask

    task automatic t_unmapped();
        wr(0, 8'h88, 32'h3, 4'h3);
        wr(0, 8'h0A, 32'h3, 4'h3);
        wr(0, 8'h04, 32'h1, 4'h3);
        rd_chk("R9 read 0x88", 1, 8'h88, 32'h0);
        rd_chk("R9 read 0x04", 1, 8'h04, 32'h0);
        rd_chk("R9 sem0 untouched", 1, sem_a(0), 32'h0);
        rd_chk("R9 sem1 untouched", 1, sem_a(1), 32'h0);
        rd_chk("R9 ctrl untouched", 1, 8'h00, 32'h0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_claim();
        t_held();
        t_release();
        t_prio();
        t_ctrl();
        t_flags();
        t_unmapped();
        repeat (2) @(posedge clk);
        finish_run();
    end
endmodule